// File: doc/BRIEF.md
# Processor-to-DRAM-controller cycle sequencer

This block sits between a processor bus and a DRAM controller that has an automatic access mode and a forced refresh mode. It watches the processor's cycle strobe, read/write line and address-decode select. From these it drives the controller's row-strobe request (RASIN, active low), its chip select and its mode-select lines, and it returns a WAIT line to the processor. Reads are launched as soon as the strobe is seen. Writes are held back a parameterised number of clocks so that write data settles before the column strobe. Only reads collect wait states.

When the controller raises its refresh request while no access is running, the block moves the controller into forced refresh mode. Any memory cycle that arrives during the refresh is stalled with WAIT. When the controller reports that the refresh is done, the block goes back to the access mode one clock later and then lets the stalled cycle run. Cycles that do not decode to memory still pulse RASIN, which gives the controller more chances to hide refreshes, but they never see WAIT.

Top module: `dram_glue_seq`

## Requirements
- R1: After reset, rasin_n is 1, mode_sel is 2'b01 (automatic access; 2'b10 is forced refresh) and wait_o is 0.
- R2: For a read that is idle-started, rasin_n goes low on the clock after the strobe is first sampled high, that is at offset 1 counted from the first strobe cycle.
- R3: For a write, rasin_n goes low at offset 1+WR_DLY and wait_o stays 0 for the whole cycle.
- R4: A local read holds wait_o high for RD_WAITS+1 cycles, counted from the first strobe cycle.
- R5: When mem_sel is 0, rasin_n still goes low with the same timing as for a local cycle, and wait_o never rises.
- R6: cs_o follows mem_sel while no access is running and holds the sampled value through the access, so it is already at its value one cycle before rasin_n falls.
- R7: A refresh request seen with no access running switches mode_sel to forced refresh on the next clock, and rasin_n stays high throughout the refresh.
- R8: A refresh request that arrives during an access is deferred. Mode stays at access until the strobe drops, and forced refresh starts two clocks after the strobe drop.
- R9: A local cycle whose strobe rises during a refresh sees wait_o held high for the rest of the refresh.
- R10: One clock after rfsh_done, mode_sel is back at access while wait_o is still high for a waiting local cycle. The stalled cycle then starts, and mode_sel never changes while rasin_n is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cyc_strb | input | 1 | Processor cycle strobe, held high for the cycle |
| cyc_wr | input | 1 | 1 = write cycle, 0 = read cycle |
| mem_sel | input | 1 | Address decodes to the DRAM array |
| rfsh_req | input | 1 | Refresh request from the controller |
| rfsh_done | input | 1 | One-clock pulse from the controller when a forced refresh ends |
| rasin_n | output | 1 | Row-strobe request to the controller, active low |
| mode_sel | output | 2 | Controller mode: 2'b01 automatic access, 2'b10 forced refresh |
| cs_o | output | 1 | Chip select to the controller |
| wait_o | output | 1 | Wait request to the processor |

## Verification
The bench targets a refresh request that lands in the middle of an access. A design that honoured it at once would switch modes while RASIN is low, and mode_sel would move before the strobe drops. It also times read and write cycles that are stalled by a refresh. A design that dropped WAIT at rfsh_done, instead of one clock later, or that put wait states on writes, would report a wrong wait count or a wrong RASIN offset. Non-local cycles are checked so that a design that suppressed RASIN, or that raised WAIT for them, is caught.

// File: rtl/dram_glue_seq.sv
module dram_glue_seq #(
  parameter int RD_WAITS = 2,
  parameter int WR_DLY   = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cyc_strb,
  input  logic       cyc_wr,
  input  logic       mem_sel,
  input  logic       rfsh_req,
  input  logic       rfsh_done,
  output logic       rasin_n,
  output logic [1:0] mode_sel,
  output logic       cs_o,
  output logic       wait_o
);
  localparam int CMAX = (RD_WAITS > WR_DLY ? RD_WAITS : WR_DLY) + 2;
  localparam int CW = $clog2(CMAX);
  localparam logic [CW-1:0] RD_LIM = CW'(RD_WAITS);
  localparam logic [CW-1:0] WR_LIM = CW'(WR_DLY);
  localparam logic [1:0] MODE_ACC  = 2'b01;
  localparam logic [1:0] MODE_RFSH = 2'b10;

  typedef enum logic [1:0] {S_IDLE, S_ACC, S_RFSH, S_RET} st_t;

  st_t          st;
  logic [CW-1:0] cnt;
  logic          is_wr, cs_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      cnt   <= '0;
      is_wr <= 1'b0;
      cs_q  <= 1'b0;
    end else begin
      case (st)
        S_IDLE:
          if (rfsh_req) st <= S_RFSH;
          else if (cyc_strb) begin
            st    <= S_ACC;
            cnt   <= '0;
            is_wr <= cyc_wr;
            cs_q  <= mem_sel;
          end
        S_ACC:
          if (!cyc_strb) st <= S_IDLE;
          else if (cnt != '1) cnt <= cnt + 1'b1;
        S_RFSH:
          if (rfsh_done) st <= S_RET;
        default:
          st <= S_IDLE;
      endcase
    end
  end

  assign rasin_n  = !(st == S_ACC && (!is_wr || cnt >= WR_LIM));
  assign mode_sel = (st == S_RFSH) ? MODE_RFSH : MODE_ACC;
  assign cs_o     = (st == S_ACC) ? cs_q : mem_sel;
  assign wait_o   = cyc_strb &&
                    ((st == S_ACC) ? (cs_q && !is_wr && cnt < RD_LIM)
                                   : (mem_sel && (st != S_IDLE || rfsh_req || !cyc_wr)));

  // R7
  idle_req_enters_rfsh_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && rfsh_req) |=> (mode_sel == MODE_RFSH && rasin_n));

  // R10
  rfsh_exit_one_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel == MODE_RFSH && rfsh_done) |=> (mode_sel == MODE_ACC && rasin_n));

  // R10
  mode_stable_under_ras_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sel != $past(mode_sel)) |-> (rasin_n && $past(rasin_n)));

  // R3
  write_no_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rasin_n && is_wr) |-> !wait_o);

  // R6
  cs_before_ras_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(rasin_n) && cs_o) |-> $past(cs_o));
endmodule

// File: tb/dram_glue_seq_tb.sv
module dram_glue_seq_tb;
  localparam int RD_WAITS = 2;
  localparam int WR_DLY   = 1;
  localparam int RF_LEN   = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cyc_strb = 0, cyc_wr = 0, mem_sel = 0, rfsh_req = 0, rfsh_done = 0;
  logic rasin_n, cs_o, wait_o;
  logic [1:0] mode_sel;

  int n_chk = 0, n_bad = 0;

  typedef struct {int off; int waits; logic cs; string req;} item_t;
  item_t sbq[$];

  always #2 clk = ~clk;

  dram_glue_seq #(.RD_WAITS(RD_WAITS), .WR_DLY(WR_DLY)) u_dut (
    .clk(clk), .rst_n(rst_n), .cyc_strb(cyc_strb), .cyc_wr(cyc_wr),
    .mem_sel(mem_sel), .rfsh_req(rfsh_req), .rfsh_done(rfsh_done),
    .rasin_n(rasin_n), .mode_sel(mode_sel), .cs_o(cs_o), .wait_o(wait_o));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  logic act = 0, csr = 0;
  int j = 0, off = -1, w = 0;
  always @(negedge clk) if (rst_n) begin
    if (cyc_strb) begin
      if (!act) begin act = 1; j = 0; off = -1; w = 0; csr = 0; end
      if (wait_o) w++;
      if (!rasin_n && off < 0) begin off = j; csr = cs_o; end
      j++;
    end else if (act) begin
      item_t e;
      act = 0;
      if (sbq.size() == 0) check(0, "scoreboard empty", 0, 1);
      else begin
        e = sbq.pop_front();
        check(off == e.off, {e.req, " ras offset"}, off, e.off);
        check(w == e.waits, {e.req, " wait count"}, w, e.waits);
        check(csr == e.cs, {e.req, " cs at ras"}, int'(csr), int'(e.cs));
      end
    end
  end

  task automatic do_cycle(input logic wr, input logic sel, input bit rf, input string req);
    item_t e;
    int pre = rf ? RF_LEN + 2 : 0;
    e.off = 1 + (wr ? WR_DLY : 0) + pre;
    e.waits = sel ? (pre + (wr ? 0 : RD_WAITS + 1)) : 0;
    e.cs = sel; e.req = req;
    sbq.push_back(e);
    if (rf) begin
      rfsh_req = 1;
      @(posedge clk); #1;
    end
    cyc_strb = 1; cyc_wr = wr; mem_sel = sel;
    if (rf) begin
      @(negedge clk);
      check(mode_sel == 2'b10, "R7 mode forced refresh", mode_sel, 2);
      check(rasin_n == 1'b1, "R7 ras high in refresh", rasin_n, 1);
      check(wait_o == sel, "R9 wait during refresh", wait_o, sel);
      repeat (RF_LEN) @(posedge clk);
      #1 rfsh_done = 1; rfsh_req = 0;
      @(posedge clk); #1 rfsh_done = 0;
      @(negedge clk);
      check(mode_sel == 2'b01, "R10 mode back one clock after done", mode_sel, 1);
      check(wait_o == sel, "R10 wait still high after done", wait_o, sel);
    end
    repeat (e.off + RD_WAITS + 2) @(posedge clk);
    #1 cyc_strb = 0;
    repeat (3) @(posedge clk);
    #1;
  endtask

  task automatic deferred_rfsh();
    item_t e;
    e.off = 1; e.waits = RD_WAITS + 1; e.cs = 1; e.req = "R8";
    sbq.push_back(e);
    cyc_strb = 1; cyc_wr = 0; mem_sel = 1;
    repeat (3) @(posedge clk);
    #1 rfsh_req = 1;
    @(negedge clk);
    check(mode_sel == 2'b01, "R8 mode held during access", mode_sel, 1);
    repeat (RD_WAITS + 2) @(posedge clk);
    #1 cyc_strb = 0;
    @(negedge clk);
    check(mode_sel == 2'b01, "R8 mode at strobe drop", mode_sel, 1);
    @(posedge clk); #1;
    @(negedge clk);
    check(mode_sel == 2'b01, "R8 mode one clock after drop", mode_sel, 1);
    @(posedge clk); #1;
    @(negedge clk);
    check(mode_sel == 2'b10, "R8 refresh two clocks after drop", mode_sel, 2);
    #1 rfsh_done = 1; rfsh_req = 0;
    @(posedge clk); #1 rfsh_done = 0;
    @(negedge clk);
    check(mode_sel == 2'b01, "R10 mode after deferred refresh", mode_sel, 1);
    repeat (3) @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    check(rasin_n == 1'b1, "R1 rasin_n reset", rasin_n, 1);
    check(mode_sel == 2'b01, "R1 mode reset", mode_sel, 1);
    check(wait_o == 1'b0, "R1 wait reset", wait_o, 0);
    @(posedge clk); #1;
    do_cycle(0, 1, 0, "R2 R4 local read");
    do_cycle(1, 1, 0, "R3 R6 local write");
    do_cycle(0, 0, 0, "R5 nonlocal read");
    do_cycle(1, 0, 0, "R5 nonlocal write");
    do_cycle(0, 1, 1, "R9 R10 read stalled by refresh");
    do_cycle(1, 1, 1, "R3 R9 write stalled by refresh");
    do_cycle(0, 0, 1, "R5 R7 nonlocal during refresh");
    deferred_rfsh();
    do_cycle(0, 1, 0, "R2 R4 read after refresh");
    check(sbq.size() == 0, "scoreboard drained", sbq.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(4 * 20000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule